// File: doc/BRIEF.md
# Neuron Partial Sum Accumulator

This block keeps the running 32-bit signed partial sum of one processing element in a neural array. A controller drives it with a one-hot command strobe and an 8-bit immediate. The commands load the bias one byte at a time, add a signed product from the multiplier, and take in a partial sum from a neighbouring element. They can also put this element's own partial sum on a shared 16-bit sigma bus.

Partial sums travel between elements as two 16-bit words, low word first. The sender issues its transmit command twice. On the matching cycles the receiver issues a low-word add and then a high-word add. The carry out of the low-word add is held in a register until the high-word add uses it. The pair of adds therefore equals one full 32-bit addition, even when other commands or idle cycles fall between them.

Top module: `psum_accum`

## Requirements
- R1: After reset is released, `psum_o` is zero, `sigma_o` is zero, no carry is pending, and the next transmit sends the low word.
- R2: A bias command on `cmd_i` bit k (k = 0..3) writes `imm_i` into bits [8k+7:8k] of the partial sum and leaves the other bytes unchanged. Issuing bits 0, 1, 2, 3 with bytes 0x53, 0xF7, 0xFF, 0xFF gives 0xFFFFF753.
- R3: The accumulate command (`cmd_i` bit 4) adds `prod_i`, taken as signed 16-bit and sign-extended, to the partial sum modulo 2^32.
- R4: The low-word receive command (`cmd_i` bit 5) replaces bits [15:0] with (bits [15:0] + `sigma_i`) mod 2^16. It leaves bits [31:16] unchanged and holds the carry out of that addition.
- R5: The high-word receive command (`cmd_i` bit 6) replaces bits [31:16] with their sum with `sigma_i` plus the held carry, then clears the carry. A low-word receive followed by a high-word receive therefore adds the full 32-bit value modulo 2^32. No other command changes the held carry.
- R6: While the transmit command (`cmd_i` bit 7) is present, `sigma_o` shows partial-sum bits [15:0] on odd-numbered valid transmits since reset and bits [31:16] on even-numbered ones. Transmitting leaves the partial sum unchanged.
- R7: `sigma_o` is zero in every cycle without a valid transmit command.
- R8: A `cmd_i` value that is zero or has more than one bit set changes none of the partial sum, the held carry or the transmit word select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 8 | One-hot command strobe: bits 0-3 bias bytes, 4 accumulate, 5 receive low, 6 receive high, 7 transmit |
| imm_i | input | 8 | Immediate byte for bias commands |
| prod_i | input | 16 | Signed product to accumulate |
| sigma_i | input | 16 | Sigma bus word received from another element |
| sigma_o | output | 16 | Sigma bus word driven by this element; zero when not transmitting |
| psum_o | output | 32 | Current partial sum |

## Verification
The hardest state to reach is a pending carry that has to survive other traffic before the high-word add uses it. The stimulus sets up a low half of 0xFFFF or near it, issues a low-word receive that overflows, and then sends idle cycles, malformed multi-bit commands and an accumulate before the high-word receive. The bench then checks that the carry is added exactly once. It also issues a second high-word receive and checks that no carry is added again. Sweeps over bias patterns and operand pairs that do or do not cross the 16-bit boundary compare every pair of adds against plain 32-bit arithmetic.

// File: rtl/psum_pkg.sv
package psum_pkg;
  localparam int SUM_W  = 32;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;
  localparam int PROD_W = 16;

  // command bit positions after the bias byte strobes
  localparam int CMD_MAC   = SUM_W / BYTE_W;
  localparam int CMD_RX_LO = CMD_MAC + 1;
  localparam int CMD_RX_HI = CMD_MAC + 2;
  localparam int CMD_TX    = CMD_MAC + 3;
  localparam int CMD_W     = CMD_MAC + 4;
endpackage

// File: rtl/psum_cmd_dec.sv
module psum_cmd_dec #(
  parameter int N_BYTES = 4,
  localparam int CmdW   = N_BYTES + 4
) (
  input  logic [CmdW-1:0]    cmd_i,
  output logic [N_BYTES-1:0] bias_we_o,
  output logic               mac_o,
  output logic               rx_lo_o,
  output logic               rx_hi_o,
  output logic               tx_o
);
  logic valid;
  assign valid = $onehot(cmd_i);

  assign bias_we_o = valid ? cmd_i[N_BYTES-1:0] : '0;
  assign mac_o     = valid & cmd_i[N_BYTES];
  assign rx_lo_o   = valid & cmd_i[N_BYTES+1];
  assign rx_hi_o   = valid & cmd_i[N_BYTES+2];
  assign tx_o      = valid & cmd_i[N_BYTES+3];
endmodule

// File: rtl/psum_datapath.sv
module psum_datapath #(
  parameter int SUM_W  = 32,
  parameter int BYTE_W = 8,
  parameter int PROD_W = 16,
  localparam int NBytes = SUM_W / BYTE_W,
  localparam int HalfW  = SUM_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBytes-1:0] bias_we_i,
  input  logic              mac_i,
  input  logic              rx_lo_i,
  input  logic              rx_hi_i,
  input  logic [BYTE_W-1:0] imm_i,
  input  logic [PROD_W-1:0] prod_i,
  input  logic [HalfW-1:0]  sigma_i,
  output logic [SUM_W-1:0]  psum_o
);
  logic [SUM_W-1:0] psum_q, psum_d;
  logic             carry_q, carry_d;
  logic [HalfW:0]   lo_sum;
  logic [HalfW-1:0] hi_sum;
  logic [SUM_W-1:0] prod_ext;

  assign prod_ext = {{(SUM_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
  assign lo_sum   = {1'b0, psum_q[HalfW-1:0]} + {1'b0, sigma_i};
  assign hi_sum   = psum_q[SUM_W-1:HalfW] + sigma_i + {{(HalfW-1){1'b0}}, carry_q};

  always_comb begin
    psum_d  = psum_q;
    carry_d = carry_q;
    for (int b = 0; b < NBytes; b++) begin
      if (bias_we_i[b]) psum_d[b*BYTE_W +: BYTE_W] = imm_i;
    end
    if (mac_i) psum_d = psum_q + prod_ext;
    if (rx_lo_i) begin
      psum_d[HalfW-1:0] = lo_sum[HalfW-1:0];
      carry_d = lo_sum[HalfW];
    end
    if (rx_hi_i) begin
      psum_d[SUM_W-1:HalfW] = hi_sum;
      carry_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psum_q  <= '0;
      carry_q <= 1'b0;
    end else begin
      psum_q  <= psum_d;
      carry_q <= carry_d;
    end
  end

  assign psum_o = psum_q;
endmodule

// File: rtl/psum_tx.sv
module psum_tx #(
  parameter int SUM_W = 32,
  localparam int HalfW = SUM_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_i,
  input  logic [SUM_W-1:0] psum_i,
  output logic [HalfW-1:0] sigma_o
);
  logic hi_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hi_sel_q <= 1'b0;
    else if (tx_i) hi_sel_q <= ~hi_sel_q;
  end

  // bus released (zero) outside transmit cycles
  assign sigma_o = !tx_i    ? '0 :
                   hi_sel_q ? psum_i[SUM_W-1:HalfW] : psum_i[HalfW-1:0];
endmodule

// File: rtl/psum_accum.sv
module psum_accum
  import psum_pkg::*;
#(
  parameter int SUM_W_P  = SUM_W,
  parameter int BYTE_W_P = BYTE_W,
  parameter int PROD_W_P = PROD_W,
  localparam int NBytes  = SUM_W_P / BYTE_W_P,
  localparam int HalfW   = SUM_W_P / 2,
  localparam int CmdW    = NBytes + 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CmdW-1:0]     cmd_i,
  input  logic [BYTE_W_P-1:0] imm_i,
  input  logic [PROD_W_P-1:0] prod_i,
  input  logic [HalfW-1:0]    sigma_i,
  output logic [HalfW-1:0]    sigma_o,
  output logic [SUM_W_P-1:0]  psum_o
);
  logic [NBytes-1:0] bias_we;
  logic mac, rx_lo, rx_hi, tx;

  psum_cmd_dec #(.N_BYTES(NBytes)) u_dec (
    .cmd_i    (cmd_i),
    .bias_we_o(bias_we),
    .mac_o    (mac),
    .rx_lo_o  (rx_lo),
    .rx_hi_o  (rx_hi),
    .tx_o     (tx)
  );

  psum_datapath #(.SUM_W(SUM_W_P), .BYTE_W(BYTE_W_P), .PROD_W(PROD_W_P)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bias_we_i(bias_we),
    .mac_i    (mac),
    .rx_lo_i  (rx_lo),
    .rx_hi_i  (rx_hi),
    .imm_i    (imm_i),
    .prod_i   (prod_i),
    .sigma_i  (sigma_i),
    .psum_o   (psum_o)
  );

  psum_tx #(.SUM_W(SUM_W_P)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tx_i   (tx),
    .psum_i (psum_o),
    .sigma_o(sigma_o)
  );
endmodule

// File: rtl/psum_accum_chk.sv
module psum_accum_chk #(
  parameter int SUM_W_P  = 32,
  parameter int BYTE_W_P = 8,
  parameter int PROD_W_P = 16,
  localparam int NBytes  = SUM_W_P / BYTE_W_P,
  localparam int HalfW   = SUM_W_P / 2,
  localparam int CmdW    = NBytes + 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [CmdW-1:0]     cmd_i,
  input logic [BYTE_W_P-1:0] imm_i,
  input logic [PROD_W_P-1:0] prod_i,
  input logic [HalfW-1:0]    sigma_i,
  input logic [HalfW-1:0]    sigma_o,
  input logic [SUM_W_P-1:0]  psum_o
);
  localparam logic [CmdW-1:0] OneC = {{(CmdW-1){1'b0}}, 1'b1};
  logic valid, v_mac, v_rxlo, v_tx, v_b0;
  logic par_q;

  assign valid  = $onehot(cmd_i);
  assign v_b0   = cmd_i == OneC;
  assign v_mac  = cmd_i == (OneC << NBytes);
  assign v_rxlo = cmd_i == (OneC << (NBytes + 1));
  assign v_tx   = cmd_i == (OneC << (NBytes + 3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   par_q <= 1'b0;
    else if (v_tx) par_q <= ~par_q;
  end

  AST_BIAS_BYTE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_b0 |=> psum_o[BYTE_W_P-1:0] == $past(imm_i)); // R2
  AST_MAC_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_mac |=> psum_o == $past(psum_o)
      + {{(SUM_W_P-PROD_W_P){$past(prod_i[PROD_W_P-1])}}, $past(prod_i)}); // R3
  AST_RXLO_HI_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_rxlo |=> $stable(psum_o[SUM_W_P-1:HalfW])); // R4
  AST_TX_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_tx |-> sigma_o == (par_q ? psum_o[SUM_W_P-1:HalfW] : psum_o[HalfW-1:0])); // R6
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_tx |=> $stable(psum_o)); // R6
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_tx |-> sigma_o == '0); // R7
  AST_BAD_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid |=> $stable(psum_o)); // R8
endmodule

bind psum_accum psum_accum_chk #(
  .SUM_W_P(SUM_W_P), .BYTE_W_P(BYTE_W_P), .PROD_W_P(PROD_W_P)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .imm_i(imm_i),
  .prod_i(prod_i), .sigma_i(sigma_i), .sigma_o(sigma_o), .psum_o(psum_o)
);

// File: tb/tb_psum_accum.sv
module tb_psum_accum;
  localparam logic [7:0] C_MAC = 8'h10, C_RXL = 8'h20, C_RXH = 8'h40, C_TX = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cmd = '0, imm = '0;
  logic [15:0] prod = '0, sig = '0;
  logic [15:0] sigma_o;
  logic [31:0] psum_o;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] e_sum = '0;
  logic        e_c = 1'b0, e_sel = 1'b0;
  logic [15:0] tx_obs;

  always #2.5 clk = ~clk;

  psum_accum dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .imm_i(imm),
    .prod_i(prod), .sigma_i(sig), .sigma_o(sigma_o), .psum_o(psum_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one command for one cycle, update model, check bus and sum
  task automatic op(input logic [7:0] c, input logic [7:0] i_imm, input logic [15:0] p,
                    input logic [15:0] s, input string tag);
    logic [16:0] lo;
    @(negedge clk);
    cmd = c; imm = i_imm; prod = p; sig = s;
    #1 tx_obs = sigma_o;
    if (c == C_TX) chk({tag, " R6 bus word"}, {16'h0, tx_obs},
                       {16'h0, e_sel ? e_sum[31:16] : e_sum[15:0]});
    else           chk({tag, " R7 bus idle"}, {16'h0, tx_obs}, 32'h0);
    @(posedge clk);
    #1 cmd = '0;
    if ($countones(c) == 1) begin
      for (int k = 0; k < 4; k++) if (c[k]) e_sum[k*8 +: 8] = i_imm;
      if (c == C_MAC) e_sum = e_sum + {{16{p[15]}}, p};
      if (c == C_RXL) begin
        lo = {1'b0, e_sum[15:0]} + {1'b0, s};
        e_sum[15:0] = lo[15:0];
        e_c = lo[16];
      end
      if (c == C_RXH) begin
        e_sum[31:16] = e_sum[31:16] + s + {15'h0, e_c};
        e_c = 1'b0;
      end
      if (c == C_TX) e_sel = ~e_sel;
    end
    chk({tag, " sum"}, psum_o, e_sum);
  endtask

  task automatic load_bias(input logic [31:0] v, input string tag);
    for (int k = 0; k < 4; k++) op(8'h1 << k, v[k*8 +: 8], 16'h0, 16'h0, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, r;
    repeat (3) @(negedge clk);
    chk("R1 reset sum", psum_o, 32'h0);
    chk("R1 reset bus", {16'h0, sigma_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sum after release", psum_o, 32'h0);

    // R2 bias example and sweep
    load_bias(32'hFFFFF753, "R2");
    chk("R2 example", psum_o, 32'hFFFFF753);
    op(8'h04, 8'h12, 16'h0, 16'h0, "R2 single byte");
    chk("R2 single byte", psum_o, 32'hFF12F753);
    for (int i = 0; i < 16; i++) begin
      a = 32'h9E3779B9 * (i + 1);
      load_bias(a, "R2 sweep");
      chk("R2 sweep full", psum_o, a);
    end

    // R3 accumulate with sign extension
    load_bias(32'h0, "R3 clr");
    r = 32'h0;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] p;
      case (i)
        0: p = 16'h7FFF; 1: p = 16'h8000; 2: p = 16'hFFFF; 3: p = 16'h0001;
        default: p = 16'(i * 4099 + 17);
      endcase
      op(C_MAC, 8'h0, p, 16'h0, "R3");
      r = r + {{16{p[15]}}, p};
      chk("R3 running", psum_o, r);
    end

    // R4/R5 word-pair receive
    for (int i = 0; i < 48; i++) begin
      case (i)
        0: begin a = 32'h0000FFFF; b = 32'h00000001; end
        1: begin a = 32'hFFFFFFFF; b = 32'h00000001; end
        2: begin a = 32'h7FFFFFFF; b = 32'h00000001; end
        3: begin a = 32'h12340000; b = 32'h0000FFFF; end
        default: begin a = 32'h6B43A9B5 * i; b = 32'hC2B2AE35 * (i + 3); end
      endcase
      load_bias(a, "R5 setup");
      op(C_RXL, 8'h0, 16'h0, b[15:0], "R4");
      chk("R4 high kept", {16'h0, psum_o[31:16]}, {16'h0, a[31:16]});
      op(C_RXH, 8'h0, 16'h0, b[31:16], "R5");
      chk("R5 pair sum", psum_o, a + b);
    end

    // R5/R8 carry held across idle, bad commands and accumulate
    load_bias(32'h0003FFFF, "R5 hold");
    op(C_RXL, 8'h0, 16'h0, 16'h0002, "R5 hold lo");
    op(8'h00, 8'h0, 16'h0, 16'h0, "R8 idle");
    op(8'h60, 8'h0, 16'h0, 16'hFFFF, "R8 two bits");
    op(8'hFF, 8'h55, 16'h1234, 16'hFFFF, "R8 all bits");
    op(C_MAC, 8'h0, 16'h0010, 16'h0, "R5 mac between");
    op(C_RXH, 8'h0, 16'h0, 16'h0000, "R5 hold hi");
    chk("R5 carry used once", psum_o, 32'h00040011);
    op(C_RXH, 8'h0, 16'h0, 16'h0000, "R5 no second carry");
    chk("R5 carry cleared", psum_o, 32'h00040011);

    // R6 transmit alternation, R8 malformed transmit does not toggle
    load_bias(32'hBEEF1234, "R6 setup");
    for (int i = 0; i < 4; i++) begin
      op(C_TX, 8'h0, 16'h0, 16'h0, "R6 tx");
      chk("R6 word", {16'h0, tx_obs}, {16'h0, (i % 2) ? 16'hBEEF : 16'h1234});
    end
    op(8'h81, 8'h77, 16'h0, 16'h0, "R8 bad tx");
    chk("R8 bad tx bus", {16'h0, tx_obs}, 32'h0);
    op(C_TX, 8'h0, 16'h0, 16'h0, "R8 sel kept");
    chk("R8 sel kept", {16'h0, tx_obs}, 32'h00001234);
    chk("R6 sum kept", psum_o, 32'hBEEF1234);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule